// File: doc/BRIEF.md
# Tamper-Protected Event Log Controller

This block runs a data-logging mission over a small on-chip log memory and keeps the host from editing what has been recorded. A host register bus with a single-cycle write strobe and a combinational read reaches a command/status register, a clock-trim register, a read-only entry counter and a read-only window onto the log words. While a mission runs, each rising edge on the event input stores the present timestamp in the next free log word.

The protection works in three ways. Host writes to the log window are dropped and leave a sticky violation flag. Any host write to a mapped location ends the mission at once. A mission can only start after a full clear sweep has zeroed every log word and reset the registers, and starting a mission uses up that cleared status. A clear is started from the command register. It takes one cycle per log word and shows a busy flag while it runs.

The register map uses address bit `IDX_W` (the top address bit) to select the log window, with the low `IDX_W` bits giving the entry index. When that bit is 0, low offsets 0, 1 and 2 select CMD/STATUS, TRIM and PTR.

Top module: `evlog_guard`

## Requirements
- R1: A read of log address index i returns log word i. A host write to the log window never changes any log word and sets `wr_violation` (status bit 5). The flag stays set until a clear command.
- R2: Writing CMD with bit 0 = 1 while no sweep is running starts a clear sweep. `clear_busy` (status bit 3) is high for exactly LOG_DEPTH cycles, every log word becomes zero, and PTR, TRIM, `log_full` and `wr_violation` are reset. `mem_cleared` (status bit 2) falls when the sweep starts and rises in the cycle `clear_busy` falls.
- R3: Writing CMD with bit 1 = 1 and bit 0 = 0 starts a mission only if `mem_cleared` is 1. Otherwise the request is refused and `mission_armed` stays 0.
- R4: An accepted start sets `mission_active` (status bit 0) and `mission_armed` (status bit 1) and clears `mem_cleared`, so a second start needs a fresh clear.
- R5: Any host write to a mapped location (log window, CMD, TRIM, PTR), other than an accepted start, drives `mission_active` and `mission_armed` to 0 at the next clock edge. Later events are not logged.
- R6: A host write to an unmapped register offset (3 and above with the top address bit 0) has no effect on any flag or register.
- R7: While `mission_active` is 1, each rising edge of `event_in` writes `time_now` into the log word at PTR, and PTR then increments. An input held high logs only once.
- R8: When PTR reaches LOG_DEPTH, `log_full` (status bit 4) is set, `mission_active` falls while `mission_armed` stays 1, and further events are not logged.
- R9: TRIM reads back the last value the host wrote to it. PTR reads back the number of logged entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | IDX_W+1 | Host address; top bit selects the log window |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Host read data for `bus_addr` (combinational) |
| event_in | input | 1 | Event input; rising edges are logged |
| time_now | input | DATA_W | Current timestamp stored with each entry |
| mission_active | output | 1 | Logging in progress |
| mission_armed | output | 1 | Mission enabled |
| mem_cleared | output | 1 | Log and registers cleared since the last mission |
| clear_busy | output | 1 | Clear sweep in progress |
| log_full | output | 1 | Log memory filled |
| wr_violation | output | 1 | Sticky flag: a host write targeted the log window |

## Verification
The bench tries to tamper with the log. It writes into the log window during a mission and checks that the stored word is unchanged and both mission flags drop. A design that forwarded the write would corrupt the record, and one that kept logging would accept events after tampering. It tries a start with no clear and a second start after a finished mission; a design that failed to consume the cleared status would re-arm over old data. It also checks the sweep length through the busy flag, a held event input (one entry, not several), a fill to the last word followed by an extra event, and a write to an unmapped offset that must leave the mission running.

// File: rtl/evlog_pkg.sv
package evlog_pkg;

    localparam int unsigned REG_CMD  = 0;
    localparam int unsigned REG_TRIM = 1;
    localparam int unsigned REG_PTR  = 2;

    localparam int unsigned CMD_CLR_BIT   = 0;
    localparam int unsigned CMD_START_BIT = 1;

    localparam int unsigned ST_ACTIVE  = 0;
    localparam int unsigned ST_ARMED   = 1;
    localparam int unsigned ST_CLEARED = 2;
    localparam int unsigned ST_BUSY    = 3;
    localparam int unsigned ST_FULL    = 4;
    localparam int unsigned ST_VIOL    = 5;
    localparam int unsigned ST_BITS    = 6;

    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_LOG  = 2'd1,
        MS_DONE = 2'd2
    } mission_e;

    typedef enum logic [2:0] {
        RG_NONE = 3'd0,
        RG_LOG  = 3'd1,
        RG_CMD  = 3'd2,
        RG_TRIM = 3'd3,
        RG_PTR  = 3'd4
    } region_e;

    typedef struct packed {
        logic    wr;
        region_e region;
        logic    clr_req;
        logic    start_req;
    } hostop_t;

    function automatic region_e classify(logic log_sel, int unsigned off);
        if (log_sel)               return RG_LOG;
        else if (off == REG_CMD)   return RG_CMD;
        else if (off == REG_TRIM)  return RG_TRIM;
        else if (off == REG_PTR)   return RG_PTR;
        else                       return RG_NONE;
    endfunction

    function automatic logic is_mapped(region_e r);
        return r != RG_NONE;
    endfunction

endpackage

// File: rtl/evlog_decode.sv
module evlog_decode
    import evlog_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned IDX_W  = 4,
    localparam int unsigned ADDR_W = IDX_W + 1
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output hostop_t           op,
    output logic [IDX_W-1:0]  idx
);
    region_e region;

    always_comb begin
        region       = classify(bus_addr[ADDR_W-1], 32'(bus_addr[IDX_W-1:0]));
        idx          = bus_addr[IDX_W-1:0];
        op.wr        = bus_wr;
        op.region    = region;
        op.clr_req   = bus_wr && (region == RG_CMD) && bus_wdata[CMD_CLR_BIT];
        op.start_req = bus_wr && (region == RG_CMD) && bus_wdata[CMD_START_BIT]
                       && !bus_wdata[CMD_CLR_BIT];
    end
endmodule

// File: rtl/evlog_clear_seq.sv
module evlog_clear_seq #(
    parameter int unsigned LOG_DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(LOG_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    output logic             busy,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LOG_DEPTH - 1);

    logic [IDX_W-1:0] sweep_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            sweep_q <= '0;
        end else if (go && !busy) begin
            busy    <= 1'b1;
            sweep_q <= '0;
        end else if (busy) begin
            if (sweep_q == LAST) busy <= 1'b0;
            else                 sweep_q <= sweep_q + 1'b1;
        end
    end

    assign wr_en  = busy;
    assign wr_idx = sweep_q;
    assign done   = busy && (sweep_q == LAST);
endmodule

// File: rtl/evlog_mission.sv
module evlog_mission
    import evlog_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned LOG_DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(LOG_DEPTH),
    localparam int unsigned CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              start_go,
    input  logic              clr_go,
    input  logic              clr_done,
    input  logic              ev_in,
    input  logic [DATA_W-1:0] ts,
    output mission_e          state,
    output logic              cleared,
    output logic              full,
    output logic [CNT_W-1:0]  count,
    output logic              log_we,
    output logic [IDX_W-1:0]  log_idx,
    output logic [DATA_W-1:0] log_data
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LOG_DEPTH - 1);

    logic ev_prev;
    logic ev_rise;

    assign ev_rise  = ev_in && !ev_prev;
    assign log_we   = (state == MS_LOG) && ev_rise && !abort && !start_go;
    assign log_idx  = count[IDX_W-1:0];
    assign log_data = ts;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= MS_IDLE;
            cleared <= 1'b0;
            full    <= 1'b0;
            count   <= '0;
            ev_prev <= 1'b0;
        end else begin
            ev_prev <= ev_in;
            if (start_go) begin
                state   <= MS_LOG;
                cleared <= 1'b0;
            end else if (abort) begin
                state <= MS_IDLE;
            end else if (log_we) begin
                count <= count + 1'b1;
                if (count == LAST_CNT) begin
                    state <= MS_DONE;
                    full  <= 1'b1;
                end
            end
            if (clr_go) begin
                count   <= '0;
                full    <= 1'b0;
                cleared <= 1'b0;
            end
            if (clr_done) cleared <= 1'b1;
        end
    end
endmodule

// File: rtl/evlog_store.sv
module evlog_store #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned LOG_DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(LOG_DEPTH)
) (
    input  logic              clk,
    input  logic              clr_we,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic              ev_we,
    input  logic [IDX_W-1:0]  ev_idx,
    input  logic [DATA_W-1:0] ev_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] words [LOG_DEPTH];

    always_ff @(posedge clk) begin
        if (clr_we)     words[clr_idx] <= '0;
        else if (ev_we) words[ev_idx]  <= ev_data;
    end

    always_comb begin
        if (32'(rd_idx) < LOG_DEPTH) rd_data = words[rd_idx];
        else                         rd_data = '0;
    end
endmodule

// File: rtl/evlog_guard.sv
module evlog_guard
    import evlog_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned LOG_DEPTH = 16,
    localparam int unsigned IDX_W  = $clog2(LOG_DEPTH),
    localparam int unsigned ADDR_W = IDX_W + 1,
    localparam int unsigned CNT_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              event_in,
    input  logic [DATA_W-1:0] time_now,
    output logic              mission_active,
    output logic              mission_armed,
    output logic              mem_cleared,
    output logic              clear_busy,
    output logic              log_full,
    output logic              wr_violation
);
    hostop_t           op;
    logic [IDX_W-1:0]  op_idx;
    logic              clr_go, start_go, abort;
    logic              sw_we, sw_done;
    logic [IDX_W-1:0]  sw_idx;
    mission_e          mstate;
    logic [CNT_W-1:0]  count;
    logic              ev_we;
    logic [IDX_W-1:0]  ev_idx;
    logic [DATA_W-1:0] ev_data;
    logic [DATA_W-1:0] log_word;
    logic [DATA_W-1:0] trim_q;
    logic              viol_q;
    logic [ST_BITS-1:0] status;

    evlog_decode #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .op        (op),
        .idx       (op_idx)
    );

    assign clr_go   = op.clr_req && !clear_busy;
    assign start_go = op.start_req && mem_cleared && !clear_busy;
    assign abort    = op.wr && is_mapped(op.region);

    evlog_clear_seq #(.LOG_DEPTH(LOG_DEPTH)) u_clr (
        .clk    (clk),
        .rst    (rst),
        .go     (clr_go),
        .busy   (clear_busy),
        .wr_en  (sw_we),
        .wr_idx (sw_idx),
        .done   (sw_done)
    );

    evlog_mission #(.DATA_W(DATA_W), .LOG_DEPTH(LOG_DEPTH)) u_msn (
        .clk      (clk),
        .rst      (rst),
        .abort    (abort),
        .start_go (start_go),
        .clr_go   (clr_go),
        .clr_done (sw_done),
        .ev_in    (event_in),
        .ts       (time_now),
        .state    (mstate),
        .cleared  (mem_cleared),
        .full     (log_full),
        .count    (count),
        .log_we   (ev_we),
        .log_idx  (ev_idx),
        .log_data (ev_data)
    );

    evlog_store #(.DATA_W(DATA_W), .LOG_DEPTH(LOG_DEPTH)) u_mem (
        .clk     (clk),
        .clr_we  (sw_we),
        .clr_idx (sw_idx),
        .ev_we   (ev_we),
        .ev_idx  (ev_idx),
        .ev_data (ev_data),
        .rd_idx  (op_idx),
        .rd_data (log_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            trim_q <= '0;
            viol_q <= 1'b0;
        end else if (clr_go) begin
            trim_q <= '0;
            viol_q <= 1'b0;
        end else if (op.wr) begin
            if (op.region == RG_TRIM) trim_q <= bus_wdata;
            if (op.region == RG_LOG)  viol_q <= 1'b1;
        end
    end

    assign mission_active = (mstate == MS_LOG);
    assign mission_armed  = (mstate == MS_LOG) || (mstate == MS_DONE);
    assign wr_violation   = viol_q;

    always_comb begin
        status              = '0;
        status[ST_ACTIVE]   = mission_active;
        status[ST_ARMED]    = mission_armed;
        status[ST_CLEARED]  = mem_cleared;
        status[ST_BUSY]     = clear_busy;
        status[ST_FULL]     = log_full;
        status[ST_VIOL]     = viol_q;
        unique case (op.region)
            RG_LOG:  bus_rdata = log_word;
            RG_CMD:  bus_rdata = DATA_W'(status);
            RG_TRIM: bus_rdata = trim_q;
            RG_PTR:  bus_rdata = DATA_W'(count);
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/evlog_guard_chk.sv
module evlog_guard_chk #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned LOG_DEPTH = 16,
    localparam int unsigned IDX_W  = $clog2(LOG_DEPTH),
    localparam int unsigned ADDR_W = IDX_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              mission_active,
    input logic              mission_armed,
    input logic              mem_cleared,
    input logic              clear_busy,
    input logic              log_full,
    input logic              wr_violation
);
    logic cmd_hit, mapped_hit, start_ok, clr_cmd;

    assign cmd_hit    = !bus_addr[ADDR_W-1] && (bus_addr[IDX_W-1:0] == '0);
    assign mapped_hit = bus_addr[ADDR_W-1] || (32'(bus_addr[IDX_W-1:0]) < 3);
    assign start_ok   = cmd_hit && bus_wdata[1] && !bus_wdata[0] && mem_cleared && !clear_busy;
    assign clr_cmd    = cmd_hit && bus_wdata[0] && !clear_busy;

    // R5
    write_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && mapped_hit && !start_ok) |=> (!mission_active && !mission_armed));

    // R3
    start_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && cmd_hit && bus_wdata[1] && !mem_cleared) |=> !mission_armed);

    // R4
    start_consume_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mission_armed) |-> !mem_cleared);

    // R8
    full_idle_chk: assert property (@(posedge clk) disable iff (rst)
        log_full |-> !mission_active);

    // R2
    busy_not_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        clear_busy |-> !mem_cleared);

    // R2
    sweep_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(clear_busy) |-> mem_cleared);

    // R1
    violation_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_violation && !(bus_wr && clr_cmd)) |=> wr_violation);

    // R8
    active_armed_chk: assert property (@(posedge clk) disable iff (rst)
        mission_active |-> mission_armed);
endmodule

bind evlog_guard evlog_guard_chk #(.DATA_W(DATA_W), .LOG_DEPTH(LOG_DEPTH)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .mission_active (mission_active),
    .mission_armed  (mission_armed),
    .mem_cleared    (mem_cleared),
    .clear_busy     (clear_busy),
    .log_full       (log_full),
    .wr_violation   (wr_violation)
);

// File: tb/evlog_guard_tb_top.sv
module evlog_guard_tb_top;
    localparam int DW    = 16;
    localparam int DEPTH = 16;
    localparam int IW    = $clog2(DEPTH);
    localparam int AW    = IW + 1;
    localparam logic [AW-1:0] A_CMD  = AW'(0);
    localparam logic [AW-1:0] A_TRIM = AW'(1);
    localparam logic [AW-1:0] A_PTR  = AW'(2);
    localparam logic [AW-1:0] A_UNM  = AW'(3);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          event_in = 1'b0;
    logic [DW-1:0] time_now = '0;
    logic mission_active, mission_armed, mem_cleared, clear_busy, log_full, wr_violation;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    logic [DW-1:0] exp_log [DEPTH];

    always #2.5 clk = ~clk;

    evlog_guard #(.DATA_W(DW), .LOG_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .event_in(event_in),
        .time_now(time_now), .mission_active(mission_active),
        .mission_armed(mission_armed), .mem_cleared(mem_cleared),
        .clear_busy(clear_busy), .log_full(log_full), .wr_violation(wr_violation)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic host_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [AW-1:0] log_addr(input int i);
        return {1'b1, IW'(i)};
    endfunction

    task automatic pulse_event(input logic [DW-1:0] ts);
        @(negedge clk);
        time_now = ts; event_in = 1'b1;
        @(negedge clk);
        event_in = 1'b0;
    endtask

    task automatic do_clear();
        host_write(A_CMD, 16'h0001);
        check(clear_busy == 1'b1, "R2 busy after clear cmd", clear_busy, 1);
        check(mem_cleared == 1'b0, "R2 cleared low during sweep", mem_cleared, 0);
        repeat (DEPTH - 1) @(negedge clk);
        check(clear_busy == 1'b1, "R2 busy still high at last word", clear_busy, 1);
        @(negedge clk);
        check(clear_busy == 1'b0, "R2 busy drops after DEPTH cycles", clear_busy, 0);
        check(mem_cleared == 1'b1, "R2 cleared set at sweep end", mem_cleared, 1);
        for (int i = 0; i < DEPTH; i++) exp_log[i] = '0;
    endtask

    task automatic start_mission();
        host_write(A_CMD, 16'h0002);
    endtask

    task automatic t_reset();
        logic [DW-1:0] st;
        host_read(A_CMD, st);
        check(st == 16'h0000, "R2 reset status word", st, 0);
    endtask

    task automatic t_start_without_clear();
        start_mission();
        check(mission_armed == 1'b0, "R3 start refused without clear", mission_armed, 0);
        check(mission_active == 1'b0, "R3 no logging without clear", mission_active, 0);
    endtask

    task automatic t_clear_contents();
        logic [DW-1:0] v;
        host_write(A_TRIM, 16'h00AA);
        host_write(log_addr(0), 16'h5555);
        do_clear();
        for (int i = 0; i < DEPTH; i++) begin
            host_read(log_addr(i), v);
            check(v == 16'h0000, "R2 log word zeroed", v, 0);
        end
        host_read(A_PTR, v);
        check(v == 16'h0000, "R2 ptr reset", v, 0);
        host_read(A_TRIM, v);
        check(v == 16'h0000, "R2 trim reset", v, 0);
        check(wr_violation == 1'b0, "R2 violation reset", wr_violation, 0);
    endtask

    task automatic t_log_events();
        logic [DW-1:0] v;
        start_mission();
        check(mission_active && mission_armed, "R4 start sets both flags",
              {mission_active, mission_armed}, 3);
        check(mem_cleared == 1'b0, "R4 start consumes cleared bit", mem_cleared, 0);
        pulse_event(16'h1001); exp_log[0] = 16'h1001;
        pulse_event(16'h1002); exp_log[1] = 16'h1002;
        @(negedge clk);
        time_now = 16'h1003; event_in = 1'b1;
        repeat (3) @(negedge clk);
        event_in = 1'b0;
        exp_log[2] = 16'h1003;
        pulse_event(16'h1004); exp_log[3] = 16'h1004;
        host_read(A_PTR, v);
        check(v == 16'd4, "R7 ptr counts entries, held input logs once", v, 4);
        for (int i = 0; i < 5; i++) begin
            host_read(log_addr(i), v);
            check(v == exp_log[i], "R7 logged timestamp", v, exp_log[i]);
        end
        check(mission_active == 1'b1, "R7 reads do not stop mission", mission_active, 1);
    endtask

    task automatic t_tamper();
        logic [DW-1:0] v;
        host_write(log_addr(1), 16'hDEAD);
        check(mission_active == 1'b0, "R5 log write ends logging", mission_active, 0);
        check(mission_armed == 1'b0, "R5 log write clears enable", mission_armed, 0);
        check(wr_violation == 1'b1, "R1 violation flag set", wr_violation, 1);
        host_read(log_addr(1), v);
        check(v == exp_log[1], "R1 log word unchanged by host write", v, exp_log[1]);
        pulse_event(16'h2222);
        host_read(A_PTR, v);
        check(v == 16'd4, "R5 events ignored after abort", v, 4);
        host_read(log_addr(4), v);
        check(v == 16'h0000, "R5 no entry after abort", v, 0);
        repeat (5) @(negedge clk);
        check(wr_violation == 1'b1, "R1 violation sticky", wr_violation, 1);
        start_mission();
        check(mission_armed == 1'b0, "R4 second start needs fresh clear", mission_armed, 0);
    endtask

    task automatic t_unmapped_and_trim();
        logic [DW-1:0] v;
        do_clear();
        start_mission();
        host_write(A_UNM, 16'hFFFF);
        check(mission_active && mission_armed, "R6 unmapped write keeps mission",
              {mission_active, mission_armed}, 3);
        check(wr_violation == 1'b0, "R6 unmapped write no violation", wr_violation, 0);
        host_read(A_TRIM, v);
        check(v == 16'h0000, "R6 unmapped write leaves trim", v, 0);
        pulse_event(16'h3001);
        host_write(A_TRIM, 16'h1234);
        check(mission_active == 1'b0 && mission_armed == 1'b0, "R5 trim write aborts",
              {mission_active, mission_armed}, 0);
        host_read(A_TRIM, v);
        check(v == 16'h1234, "R9 trim readback", v, 16'h1234);
        host_read(A_PTR, v);
        check(v == 16'd1, "R9 ptr readback", v, 1);
        host_read(log_addr(0), v);
        check(v == 16'h3001, "R7 entry kept after abort", v, 16'h3001);
    endtask

    task automatic t_fill();
        logic [DW-1:0] v;
        do_clear();
        start_mission();
        for (int i = 0; i < DEPTH; i++) begin
            pulse_event(DW'(16'h0100 + i));
            exp_log[i] = DW'(16'h0100 + i);
        end
        check(log_full == 1'b1, "R8 full flag set", log_full, 1);
        check(mission_active == 1'b0, "R8 logging stops when full", mission_active, 0);
        check(mission_armed == 1'b1, "R8 enable stays when full", mission_armed, 1);
        pulse_event(16'h0BAD);
        host_read(A_PTR, v);
        check(v == DW'(DEPTH), "R8 ptr stops at depth", v, DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            host_read(log_addr(i), v);
            check(v == exp_log[i], "R8 full log contents", v, exp_log[i]);
        end
        do_clear();
        check(log_full == 1'b0, "R2 clear resets full", log_full, 0);
        check(mission_armed == 1'b0, "R5 clear cmd ends mission", mission_armed, 0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) exp_log[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_start_without_clear();
        t_clear_contents();
        t_log_events();
        t_tamper();
        t_unmapped_and_trim();
        t_fill();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule